// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel ports, A and B, and can move a word in either direction. Each direction has its own holding register with its own clock. The A-to-B register samples port A, and the B-to-A register samples port B. An active-low output enable and a direction input pick which port, if any, the block drives. For each direction a select input picks what the driven port shows: the live word from the opposite port, or the word held in that direction's register.

The pins are three-state. Each one is modelled as a separate input vector, output vector and per-bit output-enable vector. Both registers keep sampling whether or not any output is enabled. This lets the block latch a word from one side and replay it later, or hold one word from each side while both ports are isolated. A synchronous active-high reset clears both registers. Each register sees the reset on its own clock.

Top module: `regbus_xcvr`

## Requirements
- R1: While `rst` is 1 at a rising edge of `ab_clk`, the A-to-B register is cleared to 0. While `rst` is 1 at a rising edge of `ba_clk`, the B-to-A register is cleared to 0. A driven port in stored mode then shows 0.
- R2: With `rst` at 0, each rising edge of `ab_clk` loads `a_in` into the A-to-B register. Between edges the register holds its value.
- R3: With `rst` at 0, each rising edge of `ba_clk` loads `b_in` into the B-to-A register. Between edges the register holds its value.
- R4: When `oe_n` is 0 and `dir` is 1, port B is driven: `b_oe` is all ones and `a_oe` is all zeros.
- R5: When `oe_n` is 0 and `dir` is 0, port A is driven: `a_oe` is all ones and `b_oe` is all zeros.
- R6: When `oe_n` is 1, both `a_oe` and `b_oe` are all zeros, and both `a_out` and `b_out` are 0.
- R7: While port B is driven, `b_out` equals `a_in` when `sel_ab` is 0 (live). It equals the A-to-B register when `sel_ab` is 1 (stored).
- R8: While port A is driven, `a_out` equals `b_in` when `sel_ba` is 0 (live). It equals the B-to-A register when `sel_ba` is 1 (stored).
- R9: Capture into either register happens regardless of `oe_n` and `dir`. A word taken while the ports are isolated is later shown in stored mode.
- R10: `a_oe` and `b_oe` are never both non-zero. A port that is not driven has its output vector at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ab_clk | input | 1 | Sampling clock of the A-to-B register |
| ba_clk | input | 1 | Sampling clock of the B-to-A register |
| rst | input | 1 | Synchronous active-high reset, seen on each register's own clock |
| oe_n | input | 1 | Active-low output enable; 1 isolates both ports |
| dir | input | 1 | 1 drives port B, 0 drives port A |
| sel_ab | input | 1 | Port B source: 0 live port A, 1 stored A-to-B word |
| sel_ba | input | 1 | Port A source: 0 live port B, 1 stored B-to-A word |
| a_in | input | W | Value seen on port A pins |
| a_out | output | W | Value driven onto port A |
| a_oe | output | W | Per-bit drive enable of port A |
| b_in | input | W | Value seen on port B pins |
| b_out | output | W | Value driven onto port B |
| b_oe | output | W | Per-bit drive enable of port B |

## Verification
Some rules can be checked on every cycle from the port values alone. The checker tests on every clock that the two ports are never driven together, that the enable pattern follows `oe_n` and `dir`, and that isolation zeroes every output. It also checks that a driven port in live mode follows the opposite input, and that in stored mode it shows the word sampled one edge earlier. The bench scenarios cover the rest. These are the reset clearing, holding a word across cycles without a clock edge, and capture while isolated that shows up only after the outputs are enabled again. They also cover a reset in the middle of a run that wipes a stored word.

// File: rtl/regbus_xcvr_pkg.sv
`timescale 1ns/100ps
package regbus_xcvr_pkg;
  typedef enum logic {SRC_LIVE = 1'b0, SRC_HELD = 1'b1} src_e;
  typedef enum logic [1:0] {DRV_NONE = 2'd0, DRV_PORT_A = 2'd1, DRV_PORT_B = 2'd2} drv_e;
endpackage

// File: rtl/xcv_hold_reg.sv
`timescale 1ns/100ps
module xcv_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/xcv_drive_ctrl.sv
`timescale 1ns/100ps
module xcv_drive_ctrl
  import regbus_xcvr_pkg::*;
(
  input  logic oe_n,
  input  logic dir,
  output drv_e drv
);
  always_comb begin
    if (oe_n)     drv = DRV_NONE;
    else if (dir) drv = DRV_PORT_B;
    else          drv = DRV_PORT_A;
  end
endmodule

// File: rtl/xcv_port_mux.sv
`timescale 1ns/100ps
module xcv_port_mux
  import regbus_xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         active,
  input  src_e         src,
  input  logic [W-1:0] live,
  input  logic [W-1:0] held,
  output logic [W-1:0] dout,
  output logic [W-1:0] oe
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      oe[i]   = active;
      dout[i] = active & ((src == SRC_HELD) ? held[i] : live[i]);
    end
  end
endmodule

// File: rtl/regbus_xcvr.sv
`timescale 1ns/100ps
module regbus_xcvr
  import regbus_xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         ab_clk,
  input  logic         ba_clk,
  input  logic         rst,
  input  logic         oe_n,
  input  logic         dir,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);
  logic [W-1:0] held_ab, held_ba;
  drv_e         drv;

  xcv_hold_reg #(.W(W)) u_reg_ab (.clk(ab_clk), .rst(rst), .d(a_in), .q(held_ab));
  xcv_hold_reg #(.W(W)) u_reg_ba (.clk(ba_clk), .rst(rst), .d(b_in), .q(held_ba));

  xcv_drive_ctrl u_ctrl (.oe_n(oe_n), .dir(dir), .drv(drv));

  xcv_port_mux #(.W(W)) u_mux_b (
    .active(drv == DRV_PORT_B), .src(src_e'(sel_ab)),
    .live(a_in), .held(held_ab), .dout(b_out), .oe(b_oe));

  xcv_port_mux #(.W(W)) u_mux_a (
    .active(drv == DRV_PORT_A), .src(src_e'(sel_ba)),
    .live(b_in), .held(held_ba), .dout(a_out), .oe(a_oe));
endmodule

// File: rtl/regbus_xcvr_chk.sv
`timescale 1ns/100ps
module regbus_xcvr_chk #(
  parameter int W = 8
) (
  input logic         ab_clk,
  input logic         ba_clk,
  input logic         rst,
  input logic         oe_n,
  input logic         dir,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] a_oe,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic [W-1:0] b_oe
);
  logic b_held_drv, a_held_drv;
  assign b_held_drv = (&b_oe) && sel_ab;
  assign a_held_drv = (&a_oe) && sel_ba;

  assert_one_side_R10: assert property (@(posedge ab_clk) disable iff (rst)
    !((|a_oe) && (|b_oe)));

  assert_drive_b_R4: assert property (@(posedge ab_clk) disable iff (rst)
    (!oe_n && dir) |-> ((&b_oe) && (a_oe == '0) && (a_out == '0)));

  assert_drive_a_R5: assert property (@(posedge ba_clk) disable iff (rst)
    (!oe_n && !dir) |-> ((&a_oe) && (b_oe == '0) && (b_out == '0)));

  assert_isolate_R6: assert property (@(posedge ab_clk) disable iff (rst)
    oe_n |-> (a_oe == '0 && b_oe == '0 && a_out == '0 && b_out == '0));

  assert_live_b_R7: assert property (@(posedge ab_clk) disable iff (rst)
    ((&b_oe) && !sel_ab) |-> (b_out == a_in));

  assert_held_b_R2: assert property (@(posedge ab_clk) disable iff (rst)
    b_held_drv |=> (!b_held_drv || b_out == $past(a_in)));

  assert_live_a_R8: assert property (@(posedge ba_clk) disable iff (rst)
    ((&a_oe) && !sel_ba) |-> (a_out == b_in));

  assert_held_a_R3: assert property (@(posedge ba_clk) disable iff (rst)
    a_held_drv |=> (!a_held_drv || a_out == $past(b_in)));
endmodule

bind regbus_xcvr regbus_xcvr_chk #(.W(W)) u_chk (.*);

// File: tb/regbus_xcvr_test.sv
`timescale 1ns/100ps
module regbus_xcvr_test;
  localparam int W = 8;

  logic clk = 1'b0;
  logic en_ab = 1'b0, en_ba = 1'b0;
  logic rst = 1'b1, oe_n = 1'b1, dir = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;
  logic ab_clk, ba_clk;

  always #2 clk = ~clk;
  assign ab_clk = clk & en_ab;
  assign ba_clk = clk & en_ba;

  regbus_xcvr #(.W(W)) uut (
    .ab_clk(ab_clk), .ba_clk(ba_clk), .rst(rst), .oe_n(oe_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe));

  typedef struct packed {
    logic [W-1:0] a_out, a_oe, b_out, b_oe;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0, failures = 0;
  logic  done = 1'b0;
  logic [W-1:0] m_ab = '0, m_ba = '0;

  task automatic step(input string tag, input logic r, input logic cab, input logic cba,
                      input logic oen, input logic d, input logic sab, input logic sba,
                      input logic [W-1:0] ai, input logic [W-1:0] bi);
    exp_t e;
    @(negedge clk);
    #0.5;
    rst = r; en_ab = cab; en_ba = cba; oe_n = oen; dir = d;
    sel_ab = sab; sel_ba = sba; a_in = ai; b_in = bi;
    @(posedge clk);
    if (cab) m_ab = r ? '0 : ai;
    if (cba) m_ba = r ? '0 : bi;
    e = '0;
    if (!oen && d) begin
      e.b_oe = '1; e.b_out = sab ? m_ab : ai;
    end else if (!oen && !d) begin
      e.a_oe = '1; e.a_out = sba ? m_ba : bi;
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #1;
    while (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (a_out !== e.a_out || a_oe !== e.a_oe || b_out !== e.b_out || b_oe !== e.b_oe) begin
        failures++;
        $display("FAIL %s: actual a_out=%h a_oe=%h b_out=%h b_oe=%h expected a_out=%h a_oe=%h b_out=%h b_oe=%h",
                 t, a_out, a_oe, b_out, b_oe, e.a_out, e.a_oe, e.b_out, e.b_oe);
      end
    end
  end

  initial begin
    #20000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual run unfinished, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset clears both registers, stored mode shows zero
    step("R1 reset B stored", 1, 1, 1, 0, 1, 1, 1, 8'h5A, 8'hC3);
    step("R1 reset A stored", 1, 1, 1, 0, 0, 1, 1, 8'h5A, 8'hC3);
    // R2 / R4: capture on ab_clk, B driven from register
    step("R2 R4 capture A", 0, 1, 0, 0, 1, 1, 1, 8'h3C, 8'h00);
    step("R2 hold without edge", 0, 0, 0, 0, 1, 1, 1, 8'h77, 8'h00);
    // R7: live path to B
    step("R7 live A to B", 0, 0, 0, 0, 1, 0, 1, 8'h77, 8'h00);
    step("R7 live pattern", 0, 0, 0, 0, 1, 0, 1, 8'hA5, 8'h00);
    // R3 / R5: capture on ba_clk, A driven from register
    step("R3 R5 capture B", 0, 0, 1, 0, 0, 0, 1, 8'h00, 8'h96);
    step("R3 hold without edge", 0, 0, 0, 0, 0, 0, 1, 8'h00, 8'h44);
    // R8: live path to A
    step("R8 live B to A", 0, 0, 0, 0, 0, 0, 0, 8'h00, 8'h21);
    // R6 / R9: isolation while both capture
    step("R6 R9 isolated capture", 0, 1, 1, 1, 0, 1, 1, 8'hE1, 8'h1E);
    step("R9 replay stored to B", 0, 0, 0, 0, 1, 1, 1, 8'h00, 8'h00);
    step("R9 replay stored to A", 0, 0, 0, 0, 0, 1, 1, 8'h00, 8'h00);
    // R10: undriven side stays quiet in both directions
    step("R10 only B driven", 0, 1, 1, 0, 1, 0, 0, 8'hFF, 8'hFF);
    step("R10 only A driven", 0, 1, 1, 0, 0, 0, 0, 8'hFF, 8'hFF);
    // R1: reset mid-run wipes stored words
    step("R1 mid reset", 1, 1, 1, 1, 0, 1, 1, 8'h11, 8'h22);
    step("R1 after reset B", 0, 0, 0, 0, 1, 1, 1, 8'h11, 8'h22);
    step("R1 after reset A", 0, 0, 0, 0, 0, 1, 1, 8'h11, 8'h22);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule